// File: doc/BRIEF.md
# Framed Serial Slave with Status Bit

This block is the serial end of a byte pipe between an external master and two on-chip buffers. Every exchange is one fixed frame, counted in rising edges of the serial clock: a start bit, two setup bits that pick the operation, eight data bits sent most significant bit first, and one status bit returned by the slave. The select line is active high and must stay high for the whole frame.

Written bytes go to a receive buffer through a single-cycle push strobe. Read bytes come from the head of a transmit buffer that presents its first entry without being asked, and are removed with a pop strobe. The status bit tells the master whether a written byte was kept or dropped, and whether a read byte was fresh or a repeat. A third operation returns a small buffer-status byte.

The block runs directly on the serial clock, so each rising edge of `clk` is one bit time. The buffers, any register access for software and pad timing belong to the surrounding logic.

Top module: `framed_spi_slave`

## Requirements
- R1: While reset is high, and on the first edge after it, `miso` is low and neither `rx_push` nor `tx_pop` is high.
- R2: In idle, a frame starts only on an edge where `ss` and `mosi` are both high; `ss` high with `mosi` low starts nothing.
- R3: The two setup bits (direction then address) select the operation: 1,0 reads data; 1,1 reads status; 0,0 writes data. The code 0,1 is ignored: no push or pop, `miso` stays low, and nothing starts until `ss` has been sampled low.
- R4: A data write shifts in eight bits MSB first and pushes the byte once, on the edge of the last data bit, unless `rx_full` is high. The status bit that follows is 0 when the byte was pushed and 1 when it was dropped.
- R5: A data read drives the byte MSB first; its first bit is on `miso` after the address edge. With `tx_avail` high the byte is popped on the last data edge and the status bit is 0.
- R6: A data read with the transmit buffer empty pops nothing, repeats the byte delivered by the previous read (zero after reset) and returns status bit 1.
- R7: A status read returns a byte with bit 0 = `rx_full`, bit 1 = `tx_avail` and all other bits 0, followed by status bit 0.
- R8: After a data write or read, `ss` must be sampled low at least once before another start is accepted; status reads may follow one another with `ss` held high.
- R9: `ss` low on any edge inside a frame aborts it: no push or pop follows and `miso` is low after that edge.
- R10: The status bit is on `miso` for exactly one bit time; after the next edge `miso` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; every rising edge is one bit time |
| rst | input | 1 | Synchronous reset, active high |
| ss | input | 1 | Slave select, active high |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data and status bit to the master |
| rx_push | output | 1 | Push strobe to the receive buffer |
| rx_data | output | DATA_W | Byte written into the receive buffer with `rx_push` |
| rx_full | input | 1 | Receive buffer cannot take another byte |
| tx_pop | output | 1 | Pop strobe to the transmit buffer |
| tx_data | input | DATA_W | Head entry of the transmit buffer |
| tx_avail | input | 1 | Transmit buffer holds at least one byte |

## Verification
The properties assume the buffers behave as buffers: `rx_full` and `tx_avail` change only on edges where the slave pushes or pops (or the environment refills), and the head byte stays still while `tx_avail` is high and no pop occurs. The stimulus respects this by updating its buffer model only just after a clock edge and from the strobes the slave actually raised. Frames are always driven whole and bit-aligned, except for the deliberate abort, the unused setup code and the attempts to start without releasing the select.

// File: rtl/fss_pkg.sv
package fss_pkg;

    // Frame position of the slave.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DIR,
        PH_ADDR,
        PH_DATA,
        PH_STAT,
        PH_HOLD
    } phase_e;

    // Operation, encoded as {direction, address} setup bits.
    typedef enum logic [1:0] {
        OP_WR  = 2'b00,
        OP_BAD = 2'b01,
        OP_RD  = 2'b10,
        OP_STS = 2'b11
    } op_e;

    // Datapath action for the coming edge.
    typedef enum logic [2:0] {
        ACT_CLEAR,
        ACT_LOAD_TX,
        ACT_LOAD_OLD,
        ACT_LOAD_STS,
        ACT_SHIFT,
        ACT_FINAL
    } act_e;

    typedef struct packed {
        act_e act;
        logic drive;       // shifted bits appear on miso
        logic status_bit;  // value of the trailing status bit
    } dp_cmd_t;

    function automatic op_e decode_setup(input logic dir, input logic addr);
        return op_e'({dir, addr});
    endfunction

    // Low bits of the buffer-status byte: {tx has data, rx full}.
    function automatic logic [1:0] status_bits(input logic rx_full, input logic tx_avail);
        return {tx_avail, rx_full};
    endfunction

endpackage

// File: rtl/fss_frame_ctl.sv
module fss_frame_ctl
    import fss_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ss,
    input  logic    mosi,
    input  logic    rx_full,
    input  logic    tx_avail,
    output dp_cmd_t cmd,
    output logic    rx_push,
    output logic    tx_pop
);

    localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    phase_e          phase_q, phase_d;
    op_e             op_q;
    logic            dir_q;
    logic            stale_q;
    logic [CNT_W-1:0] cnt_q;
    logic            last_bit;

    assign last_bit = (phase_q == PH_DATA) && (cnt_q == LAST_BIT) && ss;

    always_comb begin
        phase_d        = phase_q;
        cmd.act        = ACT_CLEAR;
        cmd.drive      = 1'b0;
        cmd.status_bit = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (ss && mosi) phase_d = PH_DIR;
            end
            PH_DIR: begin
                phase_d = ss ? PH_ADDR : PH_IDLE;
            end
            PH_ADDR: begin
                if (!ss) begin
                    phase_d = PH_IDLE;
                end else begin
                    unique case (decode_setup(dir_q, mosi))
                        OP_RD: begin
                            cmd.act = tx_avail ? ACT_LOAD_TX : ACT_LOAD_OLD;
                            phase_d = PH_DATA;
                        end
                        OP_STS: begin
                            cmd.act = ACT_LOAD_STS;
                            phase_d = PH_DATA;
                        end
                        OP_WR:   phase_d = PH_DATA;
                        default: phase_d = PH_HOLD;
                    endcase
                end
            end
            PH_DATA: begin
                if (!ss) begin
                    phase_d = PH_IDLE;
                end else if (cnt_q == LAST_BIT) begin
                    cmd.act = ACT_FINAL;
                    unique case (op_q)
                        OP_WR:   cmd.status_bit = rx_full;
                        OP_RD:   cmd.status_bit = stale_q;
                        default: cmd.status_bit = 1'b0;
                    endcase
                    phase_d = PH_STAT;
                end else begin
                    cmd.act   = ACT_SHIFT;
                    cmd.drive = (op_q != OP_WR);
                end
            end
            PH_STAT: begin
                if (!ss || op_q == OP_STS) phase_d = PH_IDLE;
                else                       phase_d = PH_HOLD;
            end
            PH_HOLD: begin
                if (!ss) phase_d = PH_IDLE;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    assign rx_push = last_bit && (op_q == OP_WR) && !rx_full;
    assign tx_pop  = last_bit && (op_q == OP_RD) && !stale_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_BAD;
            dir_q   <= 1'b0;
            stale_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_q == PH_DIR) dir_q <= mosi;
            if (phase_q == PH_ADDR) begin
                op_q    <= decode_setup(dir_q, mosi);
                stale_q <= !tx_avail;
                cnt_q   <= '0;
            end
            if (phase_q == PH_DATA) cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/fss_shift_path.sv
module fss_shift_path
    import fss_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  dp_cmd_t           cmd,
    input  logic              mosi,
    input  logic              rx_full,
    input  logic              tx_avail,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic [DATA_W-1:0] rx_data
);

    localparam int unsigned MSB = DATA_W - 1;
    localparam int unsigned PAD = DATA_W - 2;

    logic [DATA_W-1:0] shreg_q;
    logic [DATA_W-1:0] old_q;
    logic [DATA_W-1:0] sts_word;
    logic              miso_q;

    generate
        if (PAD > 0) begin : g_pad
            assign sts_word = {{PAD{1'b0}}, status_bits(rx_full, tx_avail)};
        end else begin : g_nopad
            assign sts_word = status_bits(rx_full, tx_avail);
        end
    endgenerate

    assign rx_data = {shreg_q[MSB-1:0], mosi};
    assign miso    = miso_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            old_q   <= '0;
            miso_q  <= 1'b0;
        end else begin
            unique case (cmd.act)
                ACT_LOAD_TX: begin
                    shreg_q <= tx_data;
                    old_q   <= tx_data;
                    miso_q  <= tx_data[MSB];
                end
                ACT_LOAD_OLD: begin
                    shreg_q <= old_q;
                    miso_q  <= old_q[MSB];
                end
                ACT_LOAD_STS: begin
                    shreg_q <= sts_word;
                    miso_q  <= sts_word[MSB];
                end
                ACT_SHIFT: begin
                    shreg_q <= {shreg_q[MSB-1:0], mosi};
                    miso_q  <= cmd.drive & shreg_q[MSB-1];
                end
                ACT_FINAL: begin
                    miso_q  <= cmd.status_bit;
                end
                default: begin
                    miso_q  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/framed_spi_slave.sv
module framed_spi_slave
    import fss_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ss,
    input  logic              mosi,
    output logic              miso,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              rx_full,
    output logic              tx_pop,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_avail
);

    dp_cmd_t cmd;

    fss_frame_ctl #(.DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .ss       (ss),
        .mosi     (mosi),
        .rx_full  (rx_full),
        .tx_avail (tx_avail),
        .cmd      (cmd),
        .rx_push  (rx_push),
        .tx_pop   (tx_pop)
    );

    fss_shift_path #(.DATA_W(DATA_W)) u_path (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .mosi     (mosi),
        .rx_full  (rx_full),
        .tx_avail (tx_avail),
        .tx_data  (tx_data),
        .miso     (miso),
        .rx_data  (rx_data)
    );

endmodule

// File: rtl/fss_checker.sv
module fss_checker (
    input logic clk,
    input logic rst,
    input logic ss,
    input logic miso,
    input logic rx_push,
    input logic rx_full,
    input logic tx_pop,
    input logic tx_avail
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!miso && !rx_push && !tx_pop)); // R1

    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rx_push && tx_pop)); // R3

    AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> (!rx_full && ss)); // R4

    AST_PUSH_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !miso); // R4

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (tx_avail && ss)); // R5

    AST_POP_STATUS_LOW: assert property (@(posedge clk) disable iff (rst)
        tx_pop |=> !miso); // R5

    AST_SINGLE_PUSH: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> !rx_push); // R8

    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ss |=> !miso); // R9

    AST_STATUS_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (rx_push || tx_pop) |=> ##1 !miso); // R10

endmodule

bind framed_spi_slave fss_checker u_fss_checker (
    .clk      (clk),
    .rst      (rst),
    .ss       (ss),
    .miso     (miso),
    .rx_push  (rx_push),
    .rx_full  (rx_full),
    .tx_pop   (tx_pop),
    .tx_avail (tx_avail)
);

// File: tb/framed_spi_slave_tb.sv
module framed_spi_slave_tb;

    localparam int RX_CAP = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ss = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic       rx_push;
    logic [7:0] rx_data;
    logic       rx_full = 1'b0;
    logic       tx_pop;
    logic [7:0] tx_data = 8'h00;
    logic       tx_avail = 1'b0;

    int         vectors = 0;
    int         fails = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic [7:0] last_rd = 8'h00;
    logic [7:0] smp_rx;

    always #5 clk = ~clk;

    framed_spi_slave #(.DATA_W(8)) u_dut (
        .clk(clk), .rst(rst), .ss(ss), .mosi(mosi), .miso(miso),
        .rx_push(rx_push), .rx_data(rx_data), .rx_full(rx_full),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp,
                       input string req, input string what);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic refresh();
        rx_full  = (rxq.size() >= RX_CAP);
        tx_avail = (txq.size() != 0);
        tx_data  = tx_avail ? txq[0] : 8'h00;
    endtask

    // One bit time: drive, compare strobes, let the edge pass, compare miso.
    task automatic step(input logic s, input logic m, input logic e_push,
                        input logic e_pop, input logic e_miso, input string req);
        logic g_push, g_pop;
        @(negedge clk);
        ss = s;
        mosi = m;
        #1;
        smp_rx = rx_data;
        g_push = rx_push;
        g_pop  = tx_pop;
        chk(8'(g_push), 8'(e_push), req, "rx_push");
        chk(8'(g_pop), 8'(e_pop), req, "tx_pop");
        @(posedge clk);
        #1;
        if (g_push) rxq.push_back(smp_rx);
        if (g_pop) txq.delete(0);
        refresh();
        chk(8'(miso), 8'(e_miso), req, "miso");
    endtask

    task automatic wr_frame(input logic [7:0] b, input bit rel, input string req);
        logic full;
        full = rx_full;
        step(1, 1, 0, 0, 0, req);
        step(1, 0, 0, 0, 0, req);
        step(1, 0, 0, 0, 0, req);
        for (int i = 7; i >= 0; i--)
            step(1, b[i], (i == 0) && !full, 0, (i == 0) ? full : 1'b0, req);
        if (!full) chk(smp_rx, b, req, "rx_data");
        step(1, 0, 0, 0, 0, "R10");
        if (rel) step(0, 0, 0, 0, 0, req);
    endtask

    task automatic rd_frame(input string req);
        logic       avail;
        logic [7:0] v;
        avail = tx_avail;
        v = avail ? txq[0] : last_rd;
        if (avail) last_rd = v;
        step(1, 1, 0, 0, 0, req);
        step(1, 1, 0, 0, 0, req);
        step(1, 0, 0, 0, v[7], req);
        for (int i = 7; i >= 0; i--)
            step(1, 0, 0, (i == 0) && avail, (i > 0) ? v[i-1] : !avail, req);
        step(1, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, req);
    endtask

    task automatic sts_frame(input bit rel, input string req);
        logic [7:0] v;
        v = {6'b0, tx_avail, rx_full};
        step(1, 1, 0, 0, 0, req);
        step(1, 1, 0, 0, 0, req);
        step(1, 1, 0, 0, v[7], req);
        for (int i = 7; i >= 0; i--)
            step(1, 0, 0, 0, (i > 0) ? v[i-1] : 1'b0, req);
        step(1, 0, 0, 0, 0, "R10");
        if (rel) step(0, 0, 0, 0, 0, req);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(8'(miso), 8'h0, "R1", "miso in reset");
        chk(8'(rx_push), 8'h0, "R1", "rx_push in reset");
        @(negedge clk);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, "R1");

        // R2: select high with mosi low does not start a frame.
        step(1, 0, 0, 0, 0, "R2");
        step(1, 0, 0, 0, 0, "R2");
        wr_frame(8'hA5, 1, "R4");
        wr_frame(8'h3C, 1, "R4");
        chk(8'(rxq.size()), 8'd2, "R4", "rx count");

        // R9: abort in the middle of a write.
        step(1, 1, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, "R9");
        step(1, 1, 0, 0, 0, "R9");
        step(1, 1, 0, 0, 0, "R9");
        step(0, 1, 0, 0, 0, "R9");
        chk(8'(rxq.size()), 8'd2, "R9", "rx count after abort");

        // R3: unused setup code is ignored until select drops.
        step(1, 1, 0, 0, 0, "R3");
        step(1, 0, 0, 0, 0, "R3");
        step(1, 1, 0, 0, 0, "R3");
        for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 0, "R3");
        step(0, 0, 0, 0, 0, "R3");
        chk(8'(rxq.size()), 8'd2, "R3", "rx count after unused code");

        // R8: no new start without releasing select after a data frame.
        wr_frame(8'h81, 0, "R8");
        for (int i = 0; i < 12; i++) step(1, 1, 0, 0, 0, "R8");
        step(0, 0, 0, 0, 0, "R8");
        chk(8'(rxq.size()), 8'd3, "R8", "rx count");

        // R4: buffer now full, byte dropped with status 1.
        wr_frame(8'h5A, 1, "R4");
        chk(8'(rxq.size()), 8'd3, "R4", "rx count when full");
        chk(rxq[2], 8'h81, "R4", "third byte");
        sts_frame(1, "R7");

        // R5/R6: reads.
        rxq.delete();
        txq.push_back(8'hC3);
        txq.push_back(8'h96);
        refresh();
        sts_frame(0, "R7");
        sts_frame(1, "R8");
        rd_frame("R5");
        rd_frame("R5");
        chk(8'(txq.size()), 8'd0, "R5", "tx count");
        rd_frame("R6");
        rd_frame("R6");
        sts_frame(1, "R7");
        wr_frame(8'h00, 1, "R4");
        wr_frame(8'hFF, 1, "R4");
        txq.push_back(8'h7E);
        refresh();
        rd_frame("R5");
        finish_run();
    end

endmodule